// File: doc/BRIEF.md
# Carry-Select Adder Slice

This block is one narrow slice of a wider adder. It takes two operand fields and a subtract control. While the slice carry-in is still in flight, it computes two candidate sums in parallel: one that assumes no incoming carry, and one that assumes an incoming carry. When the carry finally arrives, it only steers a last-stage multiplexer that picks between the two ready results.

The slice also reports two group flags to the carry network of the enclosing adder. Both flags come from range tests on the carry-free sum. The generate flag is set when that sum overflows the slice. The propagate flag is set when that sum is at or above the all-ones value. For subtraction, every bit of the second operand is inverted before the addition, and the enclosing adder supplies the initial carry. The slice holds no state and is purely combinational. The field width is a parameter with a default of 4 bits.

Top module: `csel_nibble_slice`

## Requirements
- R1: With `sub`=0 and `cin`=0, `sum` equals (a + b) mod 2^W.
- R2: With `cin`=1, `sum` equals (a + b' + 1) mod 2^W, where b' is the effective second operand.
- R3: `g` is 1 exactly when the carry-free sum a + b' is greater than 2^W-1.
- R4: `p` is 1 exactly when the carry-free sum a + b' is greater than 2^W-2.
- R5: `g` is never 1 while `p` is 0.
- R6: With `sub`=1, b' is the bitwise complement of `b`. With `sub`=1 and `cin`=1, `sum` equals (a - b) mod 2^W.
- R7: `g` and `p` do not depend on `cin`: for the same `a`, `b` and `sub`, both values of `cin` give identical flags.
- R8: All of the above hold for any field width W ≥ 1 given by parameter `SLICE_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | SLICE_W | First operand field |
| b | input | SLICE_W | Second operand field |
| sub | input | 1 | 1 = invert every bit of `b` before adding |
| cin | input | 1 | Late carry-in; selects between the two candidate sums |
| sum | output | SLICE_W | Selected result field |
| g | output | 1 | Group generate: carry-free sum overflows the slice |
| p | output | 1 | Group propagate: carry-free sum is at or above all ones |

## Verification
The bench builds two instances of the slice. One uses the default width of 4 bits. The other uses a width of 6 bits, which checks that the range tests and the inversion scale with `SLICE_W` rather than being tied to a nibble. At both widths the input space is small enough to sweep every combination of operands, `sub` and `cin`. This reaches the exact boundary sums 2^W-2, 2^W-1 and 2^W, where the propagate and generate flags change value.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef struct packed {
        logic gen;
        logic prop;
    } grp_flags_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_t;

endpackage

// File: rtl/csel_operand_prep.sv
module csel_operand_prep #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] b_in,
    input  csel_pkg::op_mode_t mode,
    output logic [SLICE_W-1:0] b_eff
);
    import csel_pkg::*;

    logic inv;
    assign inv = (mode == OP_SUB);

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign b_eff[i] = b_in[i] ^ inv;
    end

    always_comb begin
        // R6
        operand_invert_chk: assert (inv || (b_eff == b_in));
    end
endmodule

// File: rtl/csel_dual_sum.sv
module csel_dual_sum #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] op_a,
    input  logic [SLICE_W-1:0] op_b,
    output logic [SLICE_W:0]   raw_sum,
    output logic [SLICE_W-1:0] sum_zero,
    output logic [SLICE_W-1:0] sum_one
);
    localparam int WIDE = SLICE_W + 1;

    logic [WIDE-1:0] plus_one;

    assign raw_sum  = WIDE'(op_a) + WIDE'(op_b);
    assign plus_one = WIDE'(op_a) + WIDE'(op_b) + WIDE'(1);
    assign sum_zero = raw_sum[SLICE_W-1:0];
    assign sum_one  = plus_one[SLICE_W-1:0];

    always_comb begin
        // R2
        sum_pair_step_chk: assert (sum_one == SLICE_W'(sum_zero + SLICE_W'(1)));
    end
endmodule

// File: rtl/csel_group_flags.sv
module csel_group_flags #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W:0]      raw_sum,
    output csel_pkg::grp_flags_t flags
);
    logic all_ones;

    assign all_ones   = &raw_sum[SLICE_W-1:0];
    assign flags.gen  = raw_sum[SLICE_W];
    assign flags.prop = raw_sum[SLICE_W] | all_ones;

    always_comb begin
        // R5
        gen_implies_prop_chk: assert (!flags.gen || flags.prop);
        // R4
        prop_only_edge_chk: assert (!(flags.prop && !flags.gen) || all_ones);
    end
endmodule

// File: rtl/csel_nibble_slice.sv
module csel_nibble_slice #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               sub,
    input  logic               cin,
    output logic [SLICE_W-1:0] sum,
    output logic               g,
    output logic               p
);
    import csel_pkg::*;

    logic [SLICE_W-1:0] b_eff;
    logic [SLICE_W:0]   raw_sum;
    logic [SLICE_W-1:0] sum_zero;
    logic [SLICE_W-1:0] sum_one;
    grp_flags_t         flags;

    csel_operand_prep #(.SLICE_W(SLICE_W)) u_prep (
        .b_in  (b),
        .mode  (op_mode_t'(sub)),
        .b_eff (b_eff)
    );

    csel_dual_sum #(.SLICE_W(SLICE_W)) u_sums (
        .op_a     (a),
        .op_b     (b_eff),
        .raw_sum  (raw_sum),
        .sum_zero (sum_zero),
        .sum_one  (sum_one)
    );

    csel_group_flags #(.SLICE_W(SLICE_W)) u_flags (
        .raw_sum (raw_sum),
        .flags   (flags)
    );

    assign sum = cin ? sum_one : sum_zero;
    assign g   = flags.gen;
    assign p   = flags.prop;

    always_comb begin
        // R1
        select_result_chk: assert (sum == SLICE_W'(sum_zero + SLICE_W'(cin)));
        // R3
        gen_wrap_chk: assert (g == (sum_zero < a));
    end
endmodule

// File: tb/tb_csel_nibble_slice.sv
module tb_csel_nibble_slice;

    localparam int W  = 4;
    localparam int WW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W-1:0]  a, b, sum;
    logic          sub, cin, g, p;
    logic [WW-1:0] wa, wb, wsum;
    logic          wsub, wcin, wg, wp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    csel_nibble_slice #(.SLICE_W(W)) dut (
        .a(a), .b(b), .sub(sub), .cin(cin), .sum(sum), .g(g), .p(p)
    );

    csel_nibble_slice #(.SLICE_W(WW)) dut_wide (
        .a(wa), .b(wb), .sub(wsub), .cin(wcin), .sum(wsum), .g(wg), .p(wp)
    );

    // fields: a[15:12] b[11:8] sub[7] cin[6] sum[5:2] g[1] p[0]
    localparam logic [15:0] VEC [8] = '{
        {4'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0},
        {4'h7, 4'h8, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1},
        {4'h7, 4'h8, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1},
        {4'hF, 4'h1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1},
        {4'h9, 4'h3, 1'b1, 1'b1, 4'h6, 1'b1, 1'b1},
        {4'h3, 4'h9, 1'b1, 1'b1, 4'hA, 1'b0, 1'b0},
        {4'h5, 4'h5, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1},
        {4'hF, 4'hF, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sweep(input int width);
        int lim;
        int pg, pp;
        lim = 1 << width;
        pg = 0;
        pp = 0;
        for (int ia = 0; ia < lim; ia++) begin
            for (int ib = 0; ib < lim; ib++) begin
                for (int is = 0; is < 2; is++) begin
                    for (int ic = 0; ic < 2; ic++) begin
                        int be, raw, es, eg, ep, as, ag, ap;
                        @(posedge clk);
                        if (width == W) begin
                            a = W'(ia); b = W'(ib); sub = is[0]; cin = ic[0];
                        end else begin
                            wa = WW'(ia); wb = WW'(ib); wsub = is[0]; wcin = ic[0];
                        end
                        @(negedge clk);
                        be  = is ? (lim - 1 - ib) : ib;
                        raw = ia + be;
                        es  = (raw + ic) % lim;
                        eg  = (raw > lim - 1) ? 1 : 0;
                        ep  = (raw > lim - 2) ? 1 : 0;
                        if (width == W) begin
                            as = int'(sum); ag = int'(g); ap = int'(p);
                        end else begin
                            as = int'(wsum); ag = int'(wg); ap = int'(wp);
                        end
                        // R1 R2 R6 R8
                        check(as == es, is ? "R6 sum" : (ic ? "R2 sum" : "R1 sum"), as, es);
                        check(ag == eg, "R3 g", ag, eg);
                        check(ap == ep, "R4 p", ap, ep);
                        check(!(ag == 1 && ap == 0), "R5 g without p", ag, ap);
                        if (ic == 1) begin
                            // R7
                            check(ag == pg && ap == pp, "R7 flags vs cin", ag * 2 + ap, pg * 2 + pp);
                        end
                        pg = ag;
                        pp = ap;
                    end
                end
            end
        end
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0; cin = 1'b0;
        wa = '0; wb = '0; wsub = 1'b0; wcin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet inputs give zero outputs
        check(sum == 4'h0 && g == 1'b0 && p == 1'b0, "R1 idle", int'(sum), 0);

        foreach (VEC[i]) begin
            logic [15:0] v;
            v = VEC[i];
            @(posedge clk);
            a = v[15:12]; b = v[11:8]; sub = v[7]; cin = v[6];
            @(negedge clk);
            check(sum == v[5:2], v[7] ? "R6 table sum" : "R2 table sum", int'(sum), int'(v[5:2]));
            check(g == v[1], "R3 table g", int'(g), int'(v[1]));
            check(p == v[0], "R4 table p", int'(p), int'(v[0]));
        end

        // R4 edge: sum exactly all ones sets p only
        @(posedge clk); a = 4'hA; b = 4'h5; sub = 1'b0; cin = 1'b0;
        @(negedge clk);
        check(p == 1'b1 && g == 1'b0, "R4 all-ones edge", int'({g, p}), 1);
        // R3 edge: sum exactly 2^W sets g
        @(posedge clk); a = 4'h8; b = 4'h8;
        @(negedge clk);
        check(g == 1'b1 && sum == 4'h0, "R3 overflow edge", int'({g, sum}), 16);

        sweep(W);
        // R8: wider instance
        sweep(WW);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule